// File: doc/BRIEF.md
# SIMD Candidate Matching Cache

This block scans the micro-operations of a trace, one per cycle, and finds those that can be folded together into a single wide SIMD operation. Each uop it has seen and not yet merged sits in a small set-associative candidate store. The set is chosen by the uop's height in the trace dependency tree, so only uops at the same depth can combine. Inside a set, each way carries a key made of the operation code, the shared source register and a memory flag. An incoming uop whose key equals a stored key joins that group. The group stays in its way with one more lane and can then absorb further uops.

A group is refused in three cases, and the uop is then stored as a new candidate. The first case is a dependency conflict: a bit set in the incoming uop's dependency-matrix row for any lane already in the group. The second is a memory uop that does not continue the group's fixed stride. The third is a group that is already full. Each successful merge produces a one-cycle record one clock after the uop. The record names the group's first uop, the uop just added and the new lane count. Upstream asserts a ready input only once the simpler generic rewrite passes are done. A clear pulse empties the store between traces.

Top module: `simd_pair_matcher`

## Requirements
- R1: After a synchronous reset, and in the cycle after `trace_clear` is high, every candidate slot is empty and `merge_valid` is 0. A uop presented in the same cycle as `trace_clear` is dropped.
- R2: The set is selected by `uop_height`. A uop merges only with a candidate that entered at the same height.
- R3: A merge requires equal `uop_op`, equal `uop_reg` and equal `uop_is_mem` between the stored group and the incoming uop.
- R4: A merge shows one clock after the accepted uop as a one-cycle `merge_valid` pulse. `merge_head` is the index of the group's first uop, `merge_add` is the index of the incoming uop, and `merge_lanes` is the group's new lane count (2..4).
- R5: A merged group stays in its slot and keeps absorbing matching uops, so successive matches report lane counts 2, 3, 4.
- R6: A group holds at most 4 lanes. A matching uop that meets a full group is treated as a miss and stored as a new single-lane candidate, and later matches join that new candidate.
- R7: For memory uops (`uop_is_mem`=1), `uop_size` must equal the group's element size, and `uop_offset` must equal the base offset plus lanes×size (modulo 2^12). Any other memory uop is a miss.
- R8: If bit j of `uop_dep_row` is 1 for any uop index j already in a group, that group does not take the uop. If no other way can take it, the uop is stored as a new candidate.
- R9: When several ways in a set can take the uop, the lowest-numbered way wins.
- R10: A missing uop fills the lowest empty way of its set. When all 4 ways are occupied, a per-set round-robin pointer picks the victim. The pointer starts at way 0 after reset or clear and advances by one after each eviction.
- R11: While `opt_ready` is 0, uops produce no record and leave the candidate store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_clear | input | 1 | Empties the candidate store (new trace) |
| opt_ready | input | 1 | Generic passes finished; matching allowed |
| uop_valid | input | 1 | A uop descriptor is presented this cycle |
| uop_idx | input | 6 | Position of the uop inside the trace |
| uop_height | input | 3 | Dependency-tree height, selects the set |
| uop_op | input | 5 | Operation code |
| uop_reg | input | 4 | Shared (non-constant) source register |
| uop_is_mem | input | 1 | Uop is a memory access |
| uop_size | input | 4 | Memory element size in bytes |
| uop_offset | input | 12 | Memory address offset from the common base |
| uop_dep_row | input | 64 | Dependency-matrix row: bit j set means a conflict with uop j |
| merge_valid | output | 1 | A merge record is present |
| merge_head | output | 6 | Index of the group's first uop |
| merge_add | output | 6 | Index of the uop just merged |
| merge_lanes | output | 3 | Lane count of the group after the merge |

## Verification
The bench uses the default build: 8 sets, 4 ways, 4 lanes and 64 uop indices. With these values the bench can fill a set to every way in a handful of uops and push one group past its lane cap. It can also wrap the round-robin victim pointer more than once. Directed phases reach each refusal path on its own. A pseudo-random stream then confines opcodes, registers and heights to small ranges, so that hits, conflicts, stride breaks and evictions overlap in the same sets.

// File: rtl/simd_match_pkg.sv
package simd_match_pkg;

  typedef enum logic [1:0] {
    LK_MISS    = 2'd0,
    LK_MERGE   = 2'd1,
    LK_BLOCKED = 2'd2
  } lookup_e;

endpackage

// File: rtl/simd_way_match.sv
module simd_way_match #(
  parameter int NUM_UOPS = 64,
  parameter int OP_W     = 5,
  parameter int REG_W    = 4,
  parameter int OFF_W    = 12,
  parameter int SZ_W     = 4,
  parameter int MAXL     = 4,
  localparam int IDX_W   = $clog2(NUM_UOPS),
  localparam int LANE_W  = $clog2(MAXL + 1)
) (
  input  logic                    e_valid,
  input  logic [OP_W-1:0]         e_op,
  input  logic [REG_W-1:0]        e_reg,
  input  logic                    e_mem,
  input  logic [SZ_W-1:0]         e_size,
  input  logic [OFF_W-1:0]        e_base,
  input  logic [LANE_W-1:0]       e_lanes,
  input  logic [MAXL*IDX_W-1:0]   e_list,
  input  logic [OP_W-1:0]         in_op,
  input  logic [REG_W-1:0]        in_reg,
  input  logic                    in_mem,
  input  logic [SZ_W-1:0]         in_size,
  input  logic [OFF_W-1:0]        in_off,
  input  logic [NUM_UOPS-1:0]     in_dep,
  output logic                    tag_hit,
  output logic                    merge_ok
);

  logic             stride_ok;
  logic             has_room;
  logic             conflict;
  logic [OFF_W-1:0] next_off;

  assign tag_hit  = e_valid && (e_op == in_op) && (e_reg == in_reg) && (e_mem == in_mem);
  assign next_off = e_base + (OFF_W'(e_lanes) * OFF_W'(e_size));
  assign stride_ok = !in_mem || ((in_size == e_size) && (in_off == next_off));
  assign has_room = (e_lanes < LANE_W'(MAXL));

  always_comb begin
    conflict = 1'b0;
    for (int l = 0; l < MAXL; l++) begin
      if ((LANE_W'(l) < e_lanes) && in_dep[e_list[l*IDX_W +: IDX_W]]) conflict = 1'b1;
    end
  end

  assign merge_ok = tag_hit && stride_ok && has_room && !conflict;

endmodule

// File: rtl/simd_victim_pick.sv
module simd_victim_pick #(
  parameter int WAYS    = 4,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  occupied,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] victim,
  output logic             evicting
);

  logic found;

  always_comb begin
    found  = 1'b0;
    victim = rr_ptr;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !occupied[w]) begin
        found  = 1'b1;
        victim = WAY_W'(w);
      end
    end
  end

  assign evicting = !found;

endmodule

// File: rtl/simd_pair_matcher.sv
module simd_pair_matcher
  import simd_match_pkg::*;
#(
  parameter int NUM_UOPS = 64,
  parameter int SETS     = 8,
  parameter int WAYS     = 4,
  parameter int MAXL     = 4,
  parameter int OP_W     = 5,
  parameter int REG_W    = 4,
  parameter int OFF_W    = 12,
  parameter int SZ_W     = 4,
  localparam int IDX_W   = $clog2(NUM_UOPS),
  localparam int HT_W    = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int LANE_W  = $clog2(MAXL + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trace_clear,
  input  logic                opt_ready,
  input  logic                uop_valid,
  input  logic [IDX_W-1:0]    uop_idx,
  input  logic [HT_W-1:0]     uop_height,
  input  logic [OP_W-1:0]     uop_op,
  input  logic [REG_W-1:0]    uop_reg,
  input  logic                uop_is_mem,
  input  logic [SZ_W-1:0]     uop_size,
  input  logic [OFF_W-1:0]    uop_offset,
  input  logic [NUM_UOPS-1:0] uop_dep_row,
  output logic                merge_valid,
  output logic [IDX_W-1:0]    merge_head,
  output logic [IDX_W-1:0]    merge_add,
  output logic [LANE_W-1:0]   merge_lanes
);

  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  // candidate store: valid bits and round-robin pointers are reset,
  // payload arrays are plain write-enabled storage
  logic [WAYS-1:0]        e_valid [SETS];
  logic [WAY_W-1:0]       e_rr    [SETS];
  logic [OP_W-1:0]        e_op    [SETS][WAYS];
  logic [REG_W-1:0]       e_reg   [SETS][WAYS];
  logic                   e_mem   [SETS][WAYS];
  logic [SZ_W-1:0]        e_size  [SETS][WAYS];
  logic [OFF_W-1:0]       e_base  [SETS][WAYS];
  logic [LANE_W-1:0]      e_lanes [SETS][WAYS];
  logic [MAXL*IDX_W-1:0]  e_list  [SETS][WAYS];

  logic                   take;
  logic [WAYS-1:0]        hit_v;
  logic [WAYS-1:0]        ok_v;
  logic [WAYS-1:0]        win_v;
  logic [WAY_W-1:0]       win_way;
  logic [WAY_W-1:0]       ins_way;
  logic                   evicting;
  lookup_e                lk;

  assign take = uop_valid && opt_ready && !trace_clear;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    simd_way_match #(
      .NUM_UOPS(NUM_UOPS), .OP_W(OP_W), .REG_W(REG_W),
      .OFF_W(OFF_W), .SZ_W(SZ_W), .MAXL(MAXL)
    ) u_cmp (
      .e_valid (e_valid[uop_height][w]),
      .e_op    (e_op[uop_height][w]),
      .e_reg   (e_reg[uop_height][w]),
      .e_mem   (e_mem[uop_height][w]),
      .e_size  (e_size[uop_height][w]),
      .e_base  (e_base[uop_height][w]),
      .e_lanes (e_lanes[uop_height][w]),
      .e_list  (e_list[uop_height][w]),
      .in_op   (uop_op),
      .in_reg  (uop_reg),
      .in_mem  (uop_is_mem),
      .in_size (uop_size),
      .in_off  (uop_offset),
      .in_dep  (uop_dep_row),
      .tag_hit (hit_v[w]),
      .merge_ok(ok_v[w])
    );
  end

  // lowest eligible way wins
  always_comb begin
    win_v   = '0;
    win_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (ok_v[w]) begin
        win_v   = '0;
        win_v[w] = 1'b1;
        win_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (|ok_v)       lk = LK_MERGE;
    else if (|hit_v) lk = LK_BLOCKED;
    else             lk = LK_MISS;
  end

  simd_victim_pick #(.WAYS(WAYS)) u_victim (
    .occupied(e_valid[uop_height]),
    .rr_ptr  (e_rr[uop_height]),
    .victim  (ins_way),
    .evicting(evicting)
  );

  // control state and registered merge record
  always_ff @(posedge clk) begin
    if (rst || trace_clear) begin
      for (int s = 0; s < SETS; s++) begin
        e_valid[s] <= '0;
        e_rr[s]    <= '0;
      end
      merge_valid <= 1'b0;
      merge_head  <= '0;
      merge_add   <= '0;
      merge_lanes <= '0;
    end else begin
      merge_valid <= take && (lk == LK_MERGE);
      if (take && (lk == LK_MERGE)) begin
        merge_head  <= e_list[uop_height][win_way][IDX_W-1:0];
        merge_add   <= uop_idx;
        merge_lanes <= e_lanes[uop_height][win_way] + LANE_W'(1);
      end
      if (take && (lk != LK_MERGE)) begin
        e_valid[uop_height][ins_way] <= 1'b1;
        if (evicting) begin
          e_rr[uop_height] <= (e_rr[uop_height] == WAY_W'(WAYS - 1)) ? '0
                              : e_rr[uop_height] + WAY_W'(1);
        end
      end
    end
  end

  // payload storage, written on merge or insert
  always_ff @(posedge clk) begin
    if (take) begin
      if (lk == LK_MERGE) begin
        e_lanes[uop_height][win_way] <= e_lanes[uop_height][win_way] + LANE_W'(1);
        e_list[uop_height][win_way][int'(e_lanes[uop_height][win_way])*IDX_W +: IDX_W] <= uop_idx;
      end else begin
        e_op[uop_height][ins_way]    <= uop_op;
        e_reg[uop_height][ins_way]   <= uop_reg;
        e_mem[uop_height][ins_way]   <= uop_is_mem;
        e_size[uop_height][ins_way]  <= uop_size;
        e_base[uop_height][ins_way]  <= uop_offset;
        e_lanes[uop_height][ins_way] <= LANE_W'(1);
        e_list[uop_height][ins_way]  <= {{((MAXL-1)*IDX_W){1'b0}}, uop_idx};
      end
    end
  end

  // ---------------- assertions ----------------
  // R4: a record only follows an accepted uop
  a_r4_record_needs_uop: assert property (@(posedge clk) disable iff (rst)
    merge_valid |-> $past(uop_valid && opt_ready && !trace_clear));

  // R6: reported lane count stays within 2..MAXL
  a_r6_lane_bounds: assert property (@(posedge clk) disable iff (rst)
    merge_valid |-> (merge_lanes >= LANE_W'(2) && merge_lanes <= LANE_W'(MAXL)));

  // R11: no record after a cycle without ready
  a_r11_ready_gate: assert property (@(posedge clk) disable iff (rst)
    !opt_ready |=> !merge_valid);

  // R1: clear leaves no record behind
  a_r1_clear_quiet: assert property (@(posedge clk) disable iff (rst)
    trace_clear |=> !merge_valid);

  // R9: at most one winning way
  a_r9_single_winner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_v));

  // R8: a merge never picks a way the compare stage refused
  a_r8_winner_eligible: assert property (@(posedge clk) disable iff (rst)
    (take && |win_v) |-> |(win_v & ok_v & hit_v));

endmodule

// File: tb/sim_simd_pair_matcher.sv
module sim_simd_pair_matcher;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trace_clear = 1'b0;
  logic        opt_ready = 1'b0;
  logic        uop_valid = 1'b0;
  logic [5:0]  uop_idx = '0;
  logic [2:0]  uop_height = '0;
  logic [4:0]  uop_op = '0;
  logic [3:0]  uop_reg = '0;
  logic        uop_is_mem = 1'b0;
  logic [3:0]  uop_size = '0;
  logic [11:0] uop_offset = '0;
  logic [63:0] uop_dep_row = '0;
  logic        merge_valid;
  logic [5:0]  merge_head;
  logic [5:0]  merge_add;
  logic [2:0]  merge_lanes;

  always #5 clk = ~clk;

  simd_pair_matcher u0 (
    .clk(clk), .rst(rst), .trace_clear(trace_clear), .opt_ready(opt_ready),
    .uop_valid(uop_valid), .uop_idx(uop_idx), .uop_height(uop_height),
    .uop_op(uop_op), .uop_reg(uop_reg), .uop_is_mem(uop_is_mem),
    .uop_size(uop_size), .uop_offset(uop_offset), .uop_dep_row(uop_dep_row),
    .merge_valid(merge_valid), .merge_head(merge_head), .merge_add(merge_add),
    .merge_lanes(merge_lanes)
  );

  // behavioural reference model
  int m_valid [8][4];
  int m_op    [8][4];
  int m_reg   [8][4];
  int m_mem   [8][4];
  int m_size  [8][4];
  int m_base  [8][4];
  int m_lanes [8][4];
  int m_list  [8][4][4];
  int m_rr    [8];

  int exp_v = 0, exp_head = 0, exp_add = 0, exp_lanes = 0;
  int compared = 0, mismatched = 0;
  int next_idx = 0;
  bit done = 0;
  string phase = "R1 reset";

  task automatic model_clear();
    for (int s = 0; s < 8; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) m_valid[s][w] = 0;
    end
  endtask

  task automatic check_outputs();
    compared++;
    if (merge_valid !== (exp_v != 0)) begin
      mismatched++;
      $display("FAIL %s: merge_valid actual %0b expected %0d", phase, merge_valid, exp_v);
    end else if (exp_v != 0) begin
      if (merge_head != 6'(exp_head) || merge_add != 6'(exp_add) || merge_lanes != 3'(exp_lanes)) begin
        mismatched++;
        $display("FAIL %s: record actual head=%0d add=%0d lanes=%0d expected head=%0d add=%0d lanes=%0d",
                 phase, merge_head, merge_add, merge_lanes, exp_head, exp_add, exp_lanes);
      end
    end
  endtask

  // one clock: compare the previous record, then present new inputs
  task automatic step(input bit v, input bit clr, input bit rdy, input int h, input int op,
                      input int rg, input bit mem, input int sz, input int off,
                      input logic [63:0] dep);
    int idx;
    int win;
    int ins;
    @(negedge clk);
    check_outputs();
    idx = next_idx;
    exp_v = 0;
    if (clr) begin
      model_clear();
    end else if (v && rdy) begin
      win = -1;
      for (int w = 0; w < 4; w++) begin
        bit ok;
        ok = m_valid[h][w] != 0 && m_op[h][w] == op && m_reg[h][w] == rg && m_mem[h][w] == int'(mem);
        if (ok && mem) ok = (m_size[h][w] == sz) && (((m_base[h][w] + m_lanes[h][w]*m_size[h][w]) % 4096) == off);
        if (ok && m_lanes[h][w] >= 4) ok = 0;
        for (int l = 0; l < m_lanes[h][w]; l++) if (ok && dep[m_list[h][w][l]]) ok = 0;
        if (ok && win < 0) win = w;
      end
      if (win >= 0) begin
        exp_v = 1; exp_head = m_list[h][win][0]; exp_add = idx;
        m_list[h][win][m_lanes[h][win]] = idx;
        m_lanes[h][win]++;
        exp_lanes = m_lanes[h][win];
      end else begin
        ins = -1;
        for (int w = 0; w < 4; w++) if (ins < 0 && m_valid[h][w] == 0) ins = w;
        if (ins < 0) begin ins = m_rr[h]; m_rr[h] = (m_rr[h] + 1) % 4; end
        m_valid[h][ins] = 1; m_op[h][ins] = op; m_reg[h][ins] = rg; m_mem[h][ins] = int'(mem);
        m_size[h][ins] = sz; m_base[h][ins] = off; m_lanes[h][ins] = 1; m_list[h][ins][0] = idx;
      end
    end
    trace_clear = clr; opt_ready = rdy; uop_valid = v;
    uop_idx = 6'(idx); uop_height = 3'(h); uop_op = 5'(op); uop_reg = 4'(rg);
    uop_is_mem = mem; uop_size = 4'(sz); uop_offset = 12'(off); uop_dep_row = dep;
    if (v) next_idx = (next_idx + 1) % 64;
  endtask

  task automatic uop(input int h, input int op, input int rg);
    step(1, 0, 1, h, op, rg, 0, 0, 0, '0);
  endtask

  task automatic muop(input int h, input int op, input int rg, input int sz, input int off);
    step(1, 0, 1, h, op, rg, 1, sz, off, '0);
  endtask

  task automatic idle();
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, '0);
  endtask

  function automatic logic [63:0] bit_of(input int j);
    logic [63:0] r;
    r = '0;
    r[j] = 1'b1;
    return r;
  endfunction

  initial begin
    int a_idx, b_idx;
    int lfsr;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    phase = "R1 reset state";
    idle(); idle();

    phase = "R4 R5 growing group";
    uop(1, 3, 2); uop(1, 3, 2); uop(1, 3, 2);
    phase = "R6 lane cap";
    uop(1, 3, 2); uop(1, 3, 2); uop(1, 3, 2);
    phase = "R2 height selects set";
    uop(2, 3, 2); uop(2, 3, 2);
    phase = "R3 tag fields";
    uop(3, 4, 1); uop(3, 4, 2); uop(3, 5, 1);
    step(1, 0, 1, 3, 4, 1, 1, 4, 0, '0);
    uop(3, 4, 1);
    phase = "R7 memory stride";
    muop(4, 6, 7, 4, 0); muop(4, 6, 7, 4, 4); muop(4, 6, 7, 4, 12);
    muop(4, 6, 7, 4, 8); muop(4, 6, 7, 4, 16); muop(4, 6, 7, 2, 20);
    phase = "R8 R9 dependency conflict and way priority";
    a_idx = next_idx; uop(5, 1, 1);
    b_idx = next_idx; step(1, 0, 1, 5, 1, 1, 0, 0, 0, bit_of(a_idx));
    step(1, 0, 1, 5, 1, 1, 0, 0, 0, bit_of(b_idx));
    phase = "R10 replacement order";
    for (int k = 0; k < 5; k++) uop(6, 10 + k, 0);
    uop(6, 10, 0); uop(6, 11, 0); uop(6, 13, 0); uop(6, 14, 0);
    for (int k = 0; k < 4; k++) uop(6, 20 + k, 0);
    uop(6, 12, 0);
    phase = "R11 not ready ignored";
    step(1, 0, 0, 7, 2, 3, 0, 0, 0, '0);
    step(1, 0, 0, 7, 2, 3, 0, 0, 0, '0);
    uop(7, 2, 3); uop(7, 2, 3);
    phase = "R1 trace clear";
    step(1, 1, 1, 7, 2, 3, 0, 0, 0, '0);
    uop(7, 2, 3); uop(7, 2, 3); uop(1, 3, 2);
    idle();

    phase = "R7 R8 R10 mixed stream";
    lfsr = 32'h1ACE;
    for (int k = 0; k < 400; k++) begin
      int h, op, rg, sz, off;
      bit mem;
      logic [63:0] dep;
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      h = (lfsr >> 4) % 3; op = (lfsr >> 8) % 3; rg = (lfsr >> 11) % 2;
      mem = ((lfsr >> 13) % 3) == 0; sz = 4; off = ((lfsr >> 15) % 4) * 4;
      dep = ((lfsr >> 20) % 5 == 0) ? bit_of((lfsr >> 22) % 64) : '0;
      if ((lfsr >> 25) % 40 == 0) step(0, 1, 1, 0, 0, 0, 0, 0, 0, '0);
      else step(1, 0, 1, h, op, rg, mem, sz, off, dep);
    end
    idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule